// File: doc/BRIEF.md
# Mode-Aware Push Stack-Pointer Unit

This block handles the stack side of a single-operand push in an x86-style core. A start strobe arrives with the execution mode, the operand-size override flag, the stack-segment big bit and the current 64-bit stack pointer. The unit works out two sizes independently of each other. The first is the operand width: 2, 4 or 8 bytes. The second is the stack-address width: 16, 32 or 64 bits. From these it produces the decremented stack pointer, the store address and the byte count, and it pulses done once.

In wide mode the full 64-bit pointer is always used. A pushed operand is 8 bytes unless the override flag makes it 2. In legacy or compatibility mode the pointer width comes from the descriptor bit. An unprefixed push stores 4 bytes and a prefixed one stores 2. When the pointer width is narrow, only the low slice of the register is decremented and it wraps within that slice. The bits above the slice keep their value.

Top module: `push_sp_unit`

## Requirements
- R1: After reset, done is 0 and newSp, storeAddr and storeBytes are all 0.
- R2: When longMode=1 and sizeOvr=0, storeBytes is 8. With longMode=1 and sizeOvr=1 it is 2. With longMode=0 it is 4 when sizeOvr=0 and 2 when sizeOvr=1.
- R3: When longMode=1, newSp equals spIn minus storeBytes, taken modulo 2^64, and ssBig has no effect.
- R4: When longMode=0 and ssBig=1, bits 31:0 of newSp are spIn[31:0] minus storeBytes, taken modulo 2^32. Bits 63:32 equal spIn[63:32].
- R5: When longMode=0 and ssBig=0, bits 15:0 of newSp are spIn[15:0] minus storeBytes, taken modulo 2^16. Bits 63:16 equal spIn[63:16].
- R6: storeAddr equals newSp with zeros above the stack-address width: bit 16 and up for a 16-bit stack, bit 32 and up for a 32-bit stack.
- R7: newSp, storeAddr and storeBytes update on the clock edge after start is sampled high. On that same edge done rises, and it stays high for exactly one cycle.
- R8: A start that arrives while done is high is ignored. No new result appears and done drops on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe |
| longMode | input | 1 | 1 = 64-bit mode, 0 = legacy/compatibility |
| sizeOvr | input | 1 | Operand-size override prefix present |
| ssBig | input | 1 | Stack-segment descriptor big bit |
| spIn | input | 64 | Current stack-pointer register |
| newSp | output | 64 | Updated stack-pointer register value |
| storeAddr | output | 64 | Store address, truncated to stack-address width |
| storeBytes | output | 4 | Store size in bytes (2, 4 or 8) |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The assertions assume that the mode, prefix, big-bit and pointer inputs are stable on the edge where start is accepted. They read each result against the inputs registered on that edge, not against the live inputs. The bench holds every input steady through the accepting edge. It changes inputs only away from the clock edge. It also drives start back-to-back on purpose, to exercise the ignore rule.

// File: rtl/push_sp_pkg.sv
package push_sp_pkg;
  parameter int SP_W = 64;
  parameter int BC_W = 4;

  typedef enum logic [1:0] {
    ASZ_16 = 2'd0,
    ASZ_32 = 2'd1,
    ASZ_64 = 2'd2
  } addrSize_e;

  typedef struct packed {
    logic      load;
    addrSize_e asz;
    logic [BC_W-1:0] bytes;
  } ctlStrobe_t;
endpackage

// File: rtl/push_sp_ctrl.sv
module push_sp_ctrl
  import push_sp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       longMode,
  input  logic       sizeOvr,
  input  logic       ssBig,
  output ctlStrobe_t strobe,
  output logic       done
);
  logic accept;
  assign accept = start && !done;

  always_comb begin
    strobe.load = accept;
    if (longMode) begin
      strobe.asz   = ASZ_64;
      strobe.bytes = sizeOvr ? BC_W'(2) : BC_W'(8);
    end else begin
      strobe.asz   = ssBig ? ASZ_32 : ASZ_16;
      strobe.bytes = sizeOvr ? BC_W'(2) : BC_W'(4);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else       done <= accept;
  end

  // R7: done is a single-cycle pulse
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8: a start that arrives during done does not re-trigger
  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !done);
  // R7: an accepted start yields done on the next cycle
  assert_start_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !done) |=> done);
endmodule

// File: rtl/push_sp_dpath.sv
module push_sp_dpath
  import push_sp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctlStrobe_t      strobe,
  input  logic [SP_W-1:0] spIn,
  output logic [SP_W-1:0] newSp,
  output logic [SP_W-1:0] storeAddr,
  output logic [BC_W-1:0] storeBytes
);
  localparam int LO16 = 16;
  localparam int LO32 = 32;

  logic [SP_W-1:0] decFull;
  logic [SP_W-1:0] nextSp;
  logic [SP_W-1:0] nextAddr;

  assign decFull = spIn - SP_W'(strobe.bytes);

  always_comb begin
    unique case (strobe.asz)
      ASZ_16: begin
        nextSp   = {spIn[SP_W-1:LO16], decFull[LO16-1:0]};
        nextAddr = {{(SP_W-LO16){1'b0}}, decFull[LO16-1:0]};
      end
      ASZ_32: begin
        nextSp   = {spIn[SP_W-1:LO32], decFull[LO32-1:0]};
        nextAddr = {{(SP_W-LO32){1'b0}}, decFull[LO32-1:0]};
      end
      default: begin
        nextSp   = decFull;
        nextAddr = decFull;
      end
    endcase
  end

  logic [SP_W-1:0] spSeen;
  addrSize_e       aszSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      newSp      <= '0;
      storeAddr  <= '0;
      storeBytes <= '0;
      spSeen     <= '0;
      aszSeen    <= ASZ_64;
    end else if (strobe.load) begin
      newSp      <= nextSp;
      storeAddr  <= nextAddr;
      storeBytes <= strobe.bytes;
      spSeen     <= spIn;
      aszSeen    <= strobe.asz;
    end
  end

  // R4/R5: the bits above a narrow stack slice are preserved
  assert_keep_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.asz == ASZ_16) |=> newSp[SP_W-1:LO16] == spSeen[SP_W-1:LO16]);
  assert_keep_upper_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.asz == ASZ_32) |=> newSp[SP_W-1:LO32] == spSeen[SP_W-1:LO32]);
  // R6: the store address carries nothing above the stack width
  assert_addr_trunc_R6: assert property (@(posedge clk) disable iff (!rstN)
    (aszSeen == ASZ_16) |-> storeAddr[SP_W-1:LO16] == '0);
  // R2: the byte count is always 0 (reset), 2, 4 or 8
  assert_bytes_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    $countones(storeBytes) <= 1 && storeBytes[0] == 1'b0);
  // R8: results stay stable without a load
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(newSp));
endmodule

// File: rtl/push_sp_unit.sv
module push_sp_unit
  import push_sp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            longMode,
  input  logic            sizeOvr,
  input  logic            ssBig,
  input  logic [63:0]     spIn,
  output logic [63:0]     newSp,
  output logic [63:0]     storeAddr,
  output logic [3:0]      storeBytes,
  output logic            done
);
  ctlStrobe_t strobe;

  push_sp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .longMode(longMode),
    .sizeOvr(sizeOvr), .ssBig(ssBig), .strobe(strobe), .done(done)
  );

  push_sp_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .spIn(spIn),
    .newSp(newSp), .storeAddr(storeAddr), .storeBytes(storeBytes)
  );
endmodule

// File: tb/tb_push_sp_unit.sv
module tb_push_sp_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, longMode = 1'b0, sizeOvr = 1'b0, ssBig = 1'b0;
  logic [63:0] spIn = '0;
  logic [63:0] newSp, storeAddr;
  logic [3:0] storeBytes;
  logic done;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  push_sp_unit dut (
    .clk(clk), .rstN(rstN), .start(start), .longMode(longMode),
    .sizeOvr(sizeOvr), .ssBig(ssBig), .spIn(spIn), .newSp(newSp),
    .storeAddr(storeAddr), .storeBytes(storeBytes), .done(done)
  );

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic doPush(logic lm, logic ov, logic bg, logic [63:0] sp);
    @(negedge clk);
    longMode = lm; sizeOvr = ov; ssBig = bg; spIn = sp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic testReset();
    check64("R1 done", 64'(done), 0);
    check64("R1 newSp", newSp, 0);
    check64("R1 storeAddr", storeAddr, 0);
    check64("R1 storeBytes", 64'(storeBytes), 0);
  endtask

  task automatic testLong();
    doPush(1, 0, 0, 64'h0000_7fff_ffff_1000);
    check64("R2 long bytes", 64'(storeBytes), 8);
    check64("R3 long sp", newSp, 64'h0000_7fff_ffff_0ff8);
    check64("R6 long addr", storeAddr, 64'h0000_7fff_ffff_0ff8);
    check64("R7 done", 64'(done), 1);
    @(negedge clk);
    check64("R7 done drop", 64'(done), 0);
    doPush(1, 1, 1, 64'h0);
    check64("R2 long ovr bytes", 64'(storeBytes), 2);
    check64("R3 long wrap", newSp, 64'hffff_ffff_ffff_fffe);
  endtask

  task automatic testLegacy32();
    doPush(0, 0, 1, 64'hdead_beef_0000_0002);
    check64("R2 leg bytes", 64'(storeBytes), 4);
    check64("R4 wrap32", newSp, 64'hdead_beef_ffff_fffe);
    check64("R6 addr32", storeAddr, 64'h0000_0000_ffff_fffe);
    doPush(0, 1, 1, 64'h1234_5678_0000_0100);
    check64("R2 leg ovr bytes", 64'(storeBytes), 2);
    check64("R4 sp32", newSp, 64'h1234_5678_0000_00fe);
  endtask

  task automatic testLegacy16();
    doPush(0, 0, 0, 64'haaaa_bbbb_cccc_0001);
    check64("R5 wrap16", newSp, 64'haaaa_bbbb_cccc_fffd);
    check64("R6 addr16", storeAddr, 64'h0000_0000_0000_fffd);
    doPush(0, 1, 0, 64'h0000_0000_0001_0000);
    check64("R5 ovr wrap16", newSp, 64'h0000_0000_0001_fffe);
    check64("R6 addr16 b", storeAddr, 64'h0000_0000_0000_fffe);
  endtask

  task automatic testBusy();
    doPush(1, 0, 0, 64'h100);
    // start held high into the cycle where done is high
    longMode = 1; sizeOvr = 1; spIn = 64'h5000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check64("R8 done low", 64'(done), 0);
    check64("R8 sp kept", newSp, 64'hf8);
    check64("R8 bytes kept", 64'(storeBytes), 8);
  endtask

  initial begin
    fork
      begin
        #1000000;
        bad++; total++;
        $display("FAIL watchdog expired");
      end
      begin
        #12 rstN = 1'b1;
        @(negedge clk);
        testReset();
        testLong();
        testLegacy32();
        testLegacy16();
        testBusy();
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule